// File: doc/BRIEF.md
# Class-Partitioned Integer ALU

This block is a purely combinational integer ALU for a simple load/store processor datapath. It takes two operands, a shift amount and a 4-bit operation code, and returns a result word together with an overflow flag and a zero flag. No clock or register is involved: outputs follow the inputs within the same cycle. The operands and the result flow as plain combinational signals. They are not a stream, so there is no valid/ready handshake and no back-pressure.

Inside, four operation classes work on the operands at the same time: bitwise logic, add/subtract, set-on-less-than, and shifts. The two upper opcode bits pick which class result reaches the output. The two lower bits select the operation inside that class. The less-than class has no comparator of its own. It reads the sign bit and the carry of the shared adder, which is already subtracting because the compare sub-codes share their low bits with the subtract sub-codes.

Top module: `cls_alu`

## Requirements
- R1: Opcode bits [3:2] select the class that drives `res_o`: 00 logic, 01 arithmetic, 10 less-than, 11 shift.
- R2: In the logic class, opcode bits [1:0] give a bitwise operation of A and B: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R3: Opcode 0100 (signed add) and 0101 (unsigned add) both return (A + B) modulo 2^32.
- R4: Opcode 0110 (signed subtract) and 0111 (unsigned subtract) both return (A - B) modulo 2^32.
- R5: `ovf_o` is 1 only for opcodes 0100 and 0110, and only when the exact signed sum or difference lies outside [-2^31, 2^31-1]. For every other opcode it is 0.
- R6: `zero_o` is 1 exactly when the adder output is all zeros for the current opcode bits [1:0]: (A - B) when bit 1 is set, otherwise (A + B). This holds in every class.
- R7: Opcode 1010 returns 1 when A < B as two's-complement numbers, otherwise 0.
- R8: Opcode 1011 returns 1 when A < B as unsigned numbers, otherwise 0.
- R9: In the less-than class, result bits [31:1] are always 0. Sub-codes 00 and 01 return all zeros.
- R10: Opcode 1100 returns A shifted left by the shift amount with zero fill. The reserved opcode 1101 returns the same value.
- R11: Opcode 1110 returns A shifted right by the shift amount with zero fill.
- R12: Opcode 1111 returns A shifted right by the shift amount, filled with copies of A[31]. With a shift amount of 0, every shift opcode returns A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; also the value that is shifted |
| b_i | input | 32 | Second operand |
| shamt_i | input | 5 | Shift distance |
| op_i | input | 4 | Operation code: class in [3:2], sub-operation in [1:0] |
| res_o | output | 32 | Selected class result |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| zero_o | output | 1 | Adder output is all zeros |

## Verification
The overflow flag and the zero flag can both be raised by a single signed operation. Adding 0x80000000 to itself is one example: the sum wraps to zero and also overflows. Directed vectors of this kind are applied, and the bench judges both flags on that cycle against arithmetic done on wide integers. The zero flag also stays live during less-than opcodes, so equal operands must give a compare result of 0 while the zero flag reads 1. That combination is checked on the same clock.

// File: rtl/cls_alu_pkg.sv
package cls_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_CMP   = 2'b10,
    CLS_SHIFT = 2'b11
  } alu_cls_e;

  // sub-operation codes, bits [1:0]
  localparam logic [1:0] LG_AND = 2'b00;
  localparam logic [1:0] LG_OR  = 2'b01;
  localparam logic [1:0] LG_XOR = 2'b10;
  localparam logic [1:0] LG_NOR = 2'b11;

  localparam logic [1:0] CMP_SIGNED   = 2'b10;
  localparam logic [1:0] CMP_UNSIGNED = 2'b11;

  localparam logic [1:0] SH_LEFT  = 2'b00;
  localparam logic [1:0] SH_RLOG  = 2'b10;
  localparam logic [1:0] SH_RARI  = 2'b11;
endpackage

// File: rtl/cls_alu_logic.sv
module cls_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sub_i,
  output logic [WIDTH-1:0] res_o
);
  import cls_alu_pkg::*;

  always_comb begin
    unique case (sub_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/cls_alu_adder.sv
module cls_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sub_i,
  input  logic             arith_sel_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  logic             subtract;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  // bit 1 of the sub-code turns the adder into a subtractor
  assign subtract = sub_i[1];
  assign b_eff    = subtract ? ~b_i : b_i;
  assign wide     = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
  assign sum_o    = wide[WIDTH-1:0];
  assign carry_o  = wide[WIDTH];
  assign zero_o   = (sum_o == '0);

  // signed forms (bit 0 clear) report overflow, only in the arithmetic class
  assign ovf_o = arith_sel_i && !sub_i[0]
                 && (a_i[WIDTH-1] == b_eff[WIDTH-1])
                 && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/cls_alu_compare.sv
module cls_alu_compare #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       sub_i,
  input  logic             a_msb_i,
  input  logic             b_msb_i,
  input  logic             diff_msb_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o
);
  import cls_alu_pkg::*;

  logic lt;

  always_comb begin
    lt = 1'b0;
    unique case (sub_i)
      CMP_SIGNED: begin
        if (a_msb_i != b_msb_i) lt = a_msb_i;   // signs differ: negative side is less
        else                    lt = diff_msb_i;
      end
      CMP_UNSIGNED: lt = ~carry_i;              // borrow means A below B
      default:      lt = 1'b0;
    endcase
    res_o = {{(WIDTH-1){1'b0}}, lt};
  end
endmodule

// File: rtl/cls_alu_shift.sv
module cls_alu_shift #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [1:0]       sub_i,
  output logic [WIDTH-1:0] res_o
);
  import cls_alu_pkg::*;

  logic             go_right;
  logic             fill;
  logic [SHW:0][WIDTH-1:0] stage;

  assign go_right = (sub_i == SH_RLOG) || (sub_i == SH_RARI);
  assign fill     = (sub_i == SH_RARI) ? a_i[WIDTH-1] : 1'b0;
  assign stage[0] = a_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << k;
    logic [WIDTH-1:0] moved;
    always_comb begin
      if (go_right) moved = {{DIST{fill}}, stage[k][WIDTH-1:DIST]};
      else          moved = {stage[k][WIDTH-1-DIST:0], {DIST{1'b0}}};
    end
    assign stage[k+1] = shamt_i[k] ? moved : stage[k];
  end

  assign res_o = stage[SHW];
endmodule

// File: rtl/cls_alu.sv
module cls_alu #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o,
  output logic             zero_o
);
  import cls_alu_pkg::*;

  alu_cls_e         cls;
  logic [1:0]       sub;
  logic [WIDTH-1:0] logic_res, arith_res, cmp_res, shift_res;
  logic             carry;

  assign cls = alu_cls_e'(op_i[3:2]);
  assign sub = op_i[1:0];

  cls_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .sub_i(sub), .res_o(logic_res)
  );

  cls_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i(a_i), .b_i(b_i), .sub_i(sub),
    .arith_sel_i(cls == CLS_ARITH),
    .sum_o(arith_res), .carry_o(carry), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  cls_alu_compare #(.WIDTH(WIDTH)) u_cmp (
    .sub_i(sub), .a_msb_i(a_i[WIDTH-1]), .b_msb_i(b_i[WIDTH-1]),
    .diff_msb_i(arith_res[WIDTH-1]), .carry_i(carry), .res_o(cmp_res)
  );

  cls_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i(a_i), .shamt_i(shamt_i), .sub_i(sub), .res_o(shift_res)
  );

  always_comb begin
    unique case (cls)
      CLS_LOGIC: res_o = logic_res;
      CLS_ARITH: res_o = arith_res;
      CLS_CMP:   res_o = cmp_res;
      default:   res_o = shift_res;
    endcase
  end
endmodule

// File: rtl/cls_alu_chk.sv
module cls_alu_chk #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             ovf_o,
  input logic             zero_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, shamt_i, op_i})) begin
      // R5: overflow only from the signed add/subtract opcodes
      assert_ovf_scope_R5: assert (!ovf_o || (op_i[3:2] == 2'b01 && !op_i[0]));
      // R6: within the arithmetic class the zero flag mirrors the result
      if (op_i[3:2] == 2'b01)
        assert_zero_flag_R6: assert (zero_o == (res_o == '0));
      // R9: compare result is a single bit, dead sub-codes give zero
      if (op_i[3:2] == 2'b10)
        assert_cmp_narrow_R9: assert (res_o[WIDTH-1:1] == '0);
      if (op_i[3:2] == 2'b10 && !op_i[1])
        assert_cmp_dead_R9: assert (res_o == '0);
      // R12: zero shift distance passes A through
      if (op_i[3:2] == 2'b11 && shamt_i == '0)
        assert_shift_pass_R12: assert (res_o == a_i);
      // R10: reserved shift code shifts left, so bit 0 is filled with zero
      if (op_i[3:2] == 2'b11 && !op_i[1] && shamt_i != '0)
        assert_left_fill_R10: assert (res_o[0] == 1'b0);
    end
  end
endmodule

bind cls_alu cls_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i), .op_i(op_i),
  .res_o(res_o), .ovf_o(ovf_o), .zero_o(zero_o)
);

// File: tb/cls_alu_test.sv
module cls_alu_test;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [31:0] res;
  logic        ovf, zero;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  cls_alu uut (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .res_o(res), .ovf_o(ovf), .zero_o(zero)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0000, 4'b0001, 4'b0010, 4'b0011: return "R2";
      4'b0100, 4'b0101: return "R3";
      4'b0110, 4'b0111: return "R4";
      4'b1000, 4'b1001: return "R9";
      4'b1010: return "R7";
      4'b1011: return "R8";
      4'b1100, 4'b1101: return "R10";
      4'b1110: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: op=%b a=%h b=%h sh=%0d actual=%h expected=%h", req, op, a, b, sh, act, exp);
    end
  endtask

  task automatic run_vec(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] s);
    logic [31:0] e_res;
    logic        e_ovf, e_zero;
    longint      sa, sb, full;
    logic [31:0] addsub;
    @(posedge clk);
    #1;
    op = o; a = x; b = y; sh = s;
    sa = longint'($signed(x));
    sb = longint'($signed(y));
    addsub = o[1] ? (x - y) : (x + y);
    e_zero = (addsub == 32'd0);
    e_ovf  = 1'b0;
    if (o[3:2] == 2'b01 && !o[0]) begin
      full  = o[1] ? (sa - sb) : (sa + sb);
      e_ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
    end
    case (o[3:2])
      2'b00: case (o[1:0])
               2'b00: e_res = x & y;
               2'b01: e_res = x | y;
               2'b10: e_res = x ^ y;
               default: e_res = ~(x | y);
             endcase
      2'b01: e_res = addsub;
      2'b10: if (o[1:0] == 2'b10)      e_res = {31'd0, (sa < sb)};
             else if (o[1:0] == 2'b11) e_res = {31'd0, (x < y)};
             else                      e_res = 32'd0;
      default: if (o[1:0] == 2'b10)      e_res = x >> s;
               else if (o[1:0] == 2'b11) e_res = $unsigned($signed(x) >>> s);
               else                      e_res = x << s;
    endcase
    @(negedge clk);
    check({tag_of(o), " (R1 result)"}, res, e_res);
    check("R5 overflow", {31'd0, ovf}, {31'd0, e_ovf});
    check("R6 zero", {31'd0, zero}, {31'd0, e_zero});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a = '0; b = '0; sh = '0;
    @(negedge clk);
    check("R2 reset-state AND of zeros", res, 32'd0);
    check("R6 reset-state zero flag", {31'd0, zero}, 32'd1);

    // R2 logic
    for (int i = 0; i < 4; i++) run_vec(4'(i), 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd3);
    // R3/R5 add, including overflow with zero sum
    run_vec(4'b0100, 32'h8000_0000, 32'h8000_0000, 5'd0);
    run_vec(4'b0101, 32'h8000_0000, 32'h8000_0000, 5'd0);
    run_vec(4'b0100, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
    run_vec(4'b0101, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    // R4/R5 subtract
    run_vec(4'b0110, 32'h8000_0000, 32'h0000_0001, 5'd0);
    run_vec(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run_vec(4'b0111, 32'h0000_0000, 32'h0000_0001, 5'd0);
    run_vec(4'b0110, 32'h1234_5678, 32'h1234_5678, 5'd0);
    // R7/R8 less-than, equal operands keep zero flag high
    run_vec(4'b1010, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    run_vec(4'b1011, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    run_vec(4'b1010, 32'h0000_0005, 32'h0000_0005, 5'd0);
    run_vec(4'b1011, 32'h0000_0005, 32'h0000_0005, 5'd0);
    run_vec(4'b1010, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    run_vec(4'b1010, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    // R9 dead compare codes
    run_vec(4'b1000, 32'h0000_0001, 32'h0000_0002, 5'd0);
    run_vec(4'b1001, 32'h0000_0001, 32'h0000_0002, 5'd0);
    // R10/R11/R12 shifts at the ends of the range
    for (int s = 0; s < 32; s += 31) begin
      run_vec(4'b1100, 32'h8000_0001, 32'h0, 5'(s));
      run_vec(4'b1101, 32'h8000_0001, 32'h0, 5'(s));
      run_vec(4'b1110, 32'h8000_0001, 32'h0, 5'(s));
      run_vec(4'b1111, 32'h8000_0001, 32'h0, 5'(s));
    end
    run_vec(4'b1111, 32'h7000_0000, 32'h0, 5'd4);
    // mixed patterns across all opcodes
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = (n % 7 == 0) ? x : $urandom();
      if (n % 5 == 0) x[31:30] = 2'b10;
      run_vec(4'($urandom_range(0, 15)), x, y, 5'($urandom_range(0, 31)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule